// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block is the integer multiply and divide unit of a 32-bit processor core. It owns two result registers, HI and LO, and takes requests over a single start strobe carrying a 6-bit function code and two operands. Multiplies, signed or unsigned, leave the 64-bit product split across the two registers. Divides, signed or unsigned, leave the quotient in LO and the remainder in HI. Both run as a fixed 32-iteration loop of one step per clock: shift-and-add for multiply, restoring subtraction for divide. Signed operations work on magnitudes and fix the signs at the end.

The same strobe also carries the four moves between the result registers and the core's register file. The read moves return HI or LO on a data port one cycle after acceptance. The write moves load the first operand into HI or LO. A request is accepted only while the unit is idle. A request presented while the unit is busy is not taken, so the issuer must hold it, and a held read is answered only after the running operation has written its results. A zero divisor is not an error: it clears both registers and finishes at once. Reset also clears both registers.

Top module: `muldiv_unit`

## Requirements
- R1: Reset drives HI, LO, busy, done, illegal and read-valid outputs to 0.
- R2: Function code 0x18 (signed multiply) leaves the low 32 bits of the signed 64-bit product in LO and the high 32 bits in HI.
- R3: Function code 0x19 (unsigned multiply) leaves the low 32 bits of the unsigned 64-bit product in LO and the high 32 bits in HI.
- R4: Function code 0x1A (signed divide) puts the quotient, truncated toward zero, in LO and the remainder, which has the sign of the dividend, in HI. The most negative dividend over -1 gives LO = 0x80000000 and HI = 0.
- R5: Function code 0x1B (unsigned divide) puts the unsigned quotient in LO and the remainder in HI.
- R6: A divide (0x1A or 0x1B) with a zero divisor writes 0 to both HI and LO. It raises done in the cycle right after acceptance and never raises busy.
- R7: Function codes 0x11 and 0x13 copy the first operand into HI and LO respectively, one cycle after acceptance, without a done pulse.
- R8: Function codes 0x10 and 0x12 return HI and LO respectively on the read-data port, with read-valid high for one cycle, one cycle after acceptance.
- R9: A start presented while busy is not accepted. It changes neither HI nor LO, and the running operation still completes with its own result.
- R10: A read move held on the start input while busy is accepted only after completion. It returns the value just written, with read-valid high in the cycle after done.
- R11: Any other function code raises illegal for one cycle after acceptance, leaves HI and LO unchanged, and does not raise busy.
- R12: An accepted multiply or nonzero-divisor divide holds busy high for exactly 32 cycles. Done is then high for exactly one cycle, in the cycle after busy falls, and at most one of done, illegal and read-valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe; taken at a rising edge when busy_o is low |
| func_i | input | 6 | Function code of the request |
| opa_i | input | 32 | First operand: multiplicand, dividend, or the value to move into HI/LO |
| opb_i | input | 32 | Second operand: multiplier or divisor |
| busy_o | output | 1 | An iterative operation is in progress |
| done_o | output | 1 | One-cycle pulse: a multiply or divide has written HI and LO |
| illegal_o | output | 1 | One-cycle pulse: an unsupported function code was accepted |
| rdata_o | output | 32 | Value returned by a read move |
| rvalid_o | output | 1 | One-cycle pulse qualifying rdata_o |
| hi_o | output | 32 | Current HI register |
| lo_o | output | 32 | Current LO register |

## Verification
Two events can coincide. One is the final iteration of a multiply or divide writing HI/LO. The other is a pending request that is sitting on the start input, either a read move or a write move into the same registers. The bench provokes both. It queues a read move right behind a divide, so the read is held through all 32 busy cycles. It also presents a move-to-HI during a running multiply. The judgement is that the held read comes back with read-valid in the cycle after done and carries the freshly written value, not the stale one. The move issued during the busy period must leave no trace in HI once the multiply's own product has landed.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [5:0] {
        FN_MFHI  = 6'h10,
        FN_MTHI  = 6'h11,
        FN_MFLO  = 6'h12,
        FN_MTLO  = 6'h13,
        FN_MULT  = 6'h18,
        FN_MULTU = 6'h19,
        FN_DIV   = 6'h1A,
        FN_DIVU  = 6'h1B
    } md_func_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_MUL  = 2'd1,
        ENG_DIV  = 2'd2
    } md_eng_e;

endpackage

// File: rtl/md_sign_prep.sv
module md_sign_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         is_signed_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_a_o,
    output logic         neg_b_o
);
    always_comb begin
        neg_a_o = is_signed_i & a_i[W-1];
        neg_b_o = is_signed_i & b_i[W-1];
        mag_a_o = neg_a_o ? (~a_i + 1'b1) : a_i;
        mag_b_o = neg_b_o ? (~b_i + 1'b1) : b_i;
    end
endmodule

// File: rtl/md_mul_step.sv
module md_mul_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] work_i,
    input  logic [W-1:0]   mcand_i,
    output logic [2*W-1:0] work_o
);
    logic [W:0] sum;

    always_comb begin
        sum    = {1'b0, work_i[2*W-1:W]} + (work_i[0] ? {1'b0, mcand_i} : '0);
        work_o = {sum, work_i[W-1:1]};
    end
endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] work_i,
    input  logic [W-1:0]   dvsr_i,
    output logic [2*W-1:0] work_o
);
    logic [W:0] trial;

    always_comb begin
        trial = work_i[2*W-1:W-1] - {1'b0, dvsr_i};
        if (trial[W]) begin
            work_o = {work_i[2*W-2:0], 1'b0};
        end else begin
            work_o = {trial[W-1:0], work_i[W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/md_result_fix.sv
module md_result_fix #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] work_i,
    input  logic           is_div_i,
    input  logic           neg_a_i,
    input  logic           neg_b_i,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;

    always_comb begin
        prod = (neg_a_i ^ neg_b_i) ? (~work_i + 1'b1) : work_i;
        quo  = work_i[W-1:0];
        rem  = work_i[2*W-1:W];
        if (is_div_i) begin
            lo_o = (neg_a_i ^ neg_b_i) ? (~quo + 1'b1) : quo;
            hi_o = neg_a_i ? (~rem + 1'b1) : rem;
        end else begin
            lo_o = prod[W-1:0];
            hi_o = prod[2*W-1:W];
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [5:0]   func_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         illegal_o,
    output logic [W-1:0] rdata_o,
    output logic         rvalid_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

    typedef struct packed {
        logic             busy;
        md_eng_e          eng;
        logic [CNT_W-1:0] cnt;
        logic [2*W-1:0]   work;
        logic [W-1:0]     opnd;
        logic             neg_a;
        logic             neg_b;
        logic [W-1:0]     hi;
        logic [W-1:0]     lo;
        logic             done;
        logic             illegal;
        logic             rvalid;
        logic [W-1:0]     rdata;
    } md_state_t;

    md_state_t s_d, s_q;

    logic           accept;
    logic           is_signed_req;
    logic           is_div_req;
    logic           last_step;
    logic [W-1:0]   mag_a, mag_b;
    logic           neg_a, neg_b;
    logic [2*W-1:0] mul_nx, div_nx, step_work;
    logic [W-1:0]   fix_hi, fix_lo;

    assign accept        = start_i & ~s_q.busy;
    assign is_signed_req = (func_i == FN_MULT) || (func_i == FN_DIV);
    assign is_div_req    = (func_i == FN_DIV) || (func_i == FN_DIVU);
    assign last_step     = s_q.busy && (s_q.cnt == LAST_CNT);

    md_sign_prep #(.W(W)) u_prep (
        .a_i         (opa_i),
        .b_i         (opb_i),
        .is_signed_i (is_signed_req),
        .mag_a_o     (mag_a),
        .mag_b_o     (mag_b),
        .neg_a_o     (neg_a),
        .neg_b_o     (neg_b)
    );

    md_mul_step #(.W(W)) u_mul (
        .work_i  (s_q.work),
        .mcand_i (s_q.opnd),
        .work_o  (mul_nx)
    );

    md_div_step #(.W(W)) u_div (
        .work_i (s_q.work),
        .dvsr_i (s_q.opnd),
        .work_o (div_nx)
    );

    assign step_work = (s_q.eng == ENG_DIV) ? div_nx : mul_nx;

    md_result_fix #(.W(W)) u_fix (
        .work_i   (step_work),
        .is_div_i (s_q.eng == ENG_DIV),
        .neg_a_i  (s_q.neg_a),
        .neg_b_i  (s_q.neg_b),
        .hi_o     (fix_hi),
        .lo_o     (fix_lo)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.illegal = 1'b0;
        s_d.rvalid  = 1'b0;
        if (s_q.busy) begin
            s_d.work = step_work;
            s_d.cnt  = s_q.cnt + 1'b1;
            if (last_step) begin
                s_d.busy = 1'b0;
                s_d.eng  = ENG_IDLE;
                s_d.hi   = fix_hi;
                s_d.lo   = fix_lo;
                s_d.done = 1'b1;
            end
        end else if (start_i) begin
            case (func_i)
                FN_MFHI: begin
                    s_d.rvalid = 1'b1;
                    s_d.rdata  = s_q.hi;
                end
                FN_MFLO: begin
                    s_d.rvalid = 1'b1;
                    s_d.rdata  = s_q.lo;
                end
                FN_MTHI: s_d.hi = opa_i;
                FN_MTLO: s_d.lo = opa_i;
                FN_MULT, FN_MULTU: begin
                    s_d.busy  = 1'b1;
                    s_d.eng   = ENG_MUL;
                    s_d.cnt   = '0;
                    s_d.work  = {{W{1'b0}}, mag_b};
                    s_d.opnd  = mag_a;
                    s_d.neg_a = neg_a;
                    s_d.neg_b = neg_b;
                end
                FN_DIV, FN_DIVU: begin
                    if (opb_i == '0) begin
                        s_d.hi   = '0;
                        s_d.lo   = '0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.busy  = 1'b1;
                        s_d.eng   = ENG_DIV;
                        s_d.cnt   = '0;
                        s_d.work  = {{W{1'b0}}, mag_a};
                        s_d.opnd  = mag_b;
                        s_d.neg_a = neg_a;
                        s_d.neg_b = neg_b;
                    end
                end
                default: s_d.illegal = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = s_q.busy;
    assign done_o    = s_q.done;
    assign illegal_o = s_q.illegal;
    assign rdata_o   = s_q.rdata;
    assign rvalid_o  = s_q.rvalid;
    assign hi_o      = s_q.hi;
    assign lo_o      = s_q.lo;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R12

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, illegal_o, rvalid_o})); // R12

    AST_HILO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_step) |=> ($stable(hi_o) && $stable(lo_o))); // R9

    AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !busy_o); // R11

    AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> !busy_o); // R8

    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_div_req && (opb_i == '0)) |=>
            (hi_o == '0 && lo_o == '0 && done_o && !busy_o)); // R6

endmodule

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
    import muldiv_pkg::*;

    typedef struct {
        int          kind;   // 0 done, 1 read, 2 illegal
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] data;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  func_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        busy_o, done_o, illegal_o, rvalid_o;
    logic [31:0] rdata_o, hi_o, lo_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;
    exp_t sb[$];

    always #4 clk = ~clk;

    muldiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .func_i(func_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .illegal_o(illegal_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .hi_o(hi_o), .lo_o(lo_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input string req);
        exp_t e;
        longint sa, sb_, q, r;
        longint unsigned ua, ub, p;
        e.req = req; e.data = '0; e.kind = 0;
        case (f)
            6'h18: begin
                sa = longint'($signed(a)); sb_ = longint'($signed(b));
                p = longint'(sa * sb_);
                m_hi = p[63:32]; m_lo = p[31:0];
            end
            6'h19: begin
                ua = {32'b0, a}; ub = {32'b0, b}; p = ua * ub;
                m_hi = p[63:32]; m_lo = p[31:0];
            end
            6'h1A: begin
                if (b == 0) begin m_hi = 0; m_lo = 0; end
                else begin
                    sa = longint'($signed(a)); sb_ = longint'($signed(b));
                    q = sa / sb_; r = sa % sb_;
                    m_lo = q[31:0]; m_hi = r[31:0];
                end
            end
            6'h1B: begin
                if (b == 0) begin m_hi = 0; m_lo = 0; end
                else begin m_lo = a / b; m_hi = a % b; end
            end
            6'h10: begin e.kind = 1; e.data = m_hi; end
            6'h12: begin e.kind = 1; e.data = m_lo; end
            6'h11: begin m_hi = a; e.kind = -1; end
            6'h13: begin m_lo = a; e.kind = -1; end
            default: e.kind = 2;
        endcase
        e.hi = m_hi; e.lo = m_lo;
        if (e.kind >= 0) sb.push_back(e);
    endtask

    // Drive a request, hold it until accepted; returns at the first negedge after acceptance.
    task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input string req);
        logic was_busy;
        model(f, a, b, req);
        @(negedge clk);
        start_i = 1'b1; func_i = f; opa_i = a; opb_i = b;
        forever begin
            was_busy = busy_o;
            @(posedge clk);
            if (!was_busy) break;
            @(negedge clk);
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_iter_timing(input string req);
        int bad = 0;
        for (int k = 1; k <= 32; k++) begin
            if (!busy_o || done_o) bad++;
            @(negedge clk);
        end
        check(bad == 0, req, bad, 0);
        check(done_o && !busy_o, req, {done_o, busy_o}, 2'b10);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rvalid_o && busy_o) check(1'b0, "R8", 1, 0);
            if (done_o || rvalid_o || illegal_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "unexpected event", {done_o, rvalid_o, illegal_o}, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    case (e.kind)
                        0: check(done_o && hi_o == e.hi && lo_o == e.lo, e.req,
                                 {hi_o, lo_o}, {e.hi, e.lo});
                        1: check(rvalid_o && rdata_o == e.data, e.req, rdata_o, e.data);
                        default: check(illegal_o && hi_o == e.hi && lo_o == e.lo, e.req,
                                       {hi_o, lo_o}, {e.hi, e.lo});
                    endcase
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(hi_o == 0 && lo_o == 0 && !busy_o && !done_o && !illegal_o && !rvalid_o,
              "R1 reset", {hi_o, lo_o}, 0);
        rst_n = 1'b1;

        // R2 signed multiply with timing (R12)
        issue(6'h18, -32'sd7, 32'sd6, "R2 mult neg");
        check_iter_timing("R12 mult busy window");
        drain();
        issue(6'h18, 32'h8000_0000, 32'h8000_0000, "R2 mult min*min");
        drain();
        issue(6'h18, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R2 mult max*-1");
        drain();
        // R3 unsigned multiply
        issue(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 multu max");
        drain();
        issue(6'h19, 32'h1234_5678, 32'h9ABC_DEF0, "R3 multu mix");
        drain();
        // R4 signed divide
        issue(6'h1A, -32'sd7, 32'sd2, "R4 div -7/2");
        check_iter_timing("R12 div busy window");
        drain();
        issue(6'h1A, 32'sd7, -32'sd2, "R4 div 7/-2");
        drain();
        issue(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, "R4 div min/-1");
        drain();
        // R5 unsigned divide
        issue(6'h1B, 32'hFFFF_FFFF, 32'd7, "R5 divu");
        drain();
        issue(6'h1B, 32'd3, 32'hFFFF_FFF0, "R5 divu small");
        drain();
        // R6 zero divisor
        issue(6'h1A, -32'sd5, 32'd0, "R6 div zero");
        check(done_o && !busy_o, "R6 immediate done", {done_o, busy_o}, 2'b10);
        drain();
        issue(6'h19, 32'hFFFF_0000, 32'h10, "R3 preload");
        drain();
        issue(6'h1B, 32'd99, 32'd0, "R6 divu zero");
        drain();
        // R7 moves into HI/LO, R8 moves out
        issue(6'h11, 32'hCAFE_0001, 32'd0, "R7 mthi");
        check(hi_o == 32'hCAFE_0001 && !done_o, "R7 mthi", hi_o, 32'hCAFE_0001);
        issue(6'h13, 32'hBEEF_0002, 32'd0, "R7 mtlo");
        check(lo_o == 32'hBEEF_0002 && !done_o, "R7 mtlo", lo_o, 32'hBEEF_0002);
        issue(6'h10, 32'd0, 32'd0, "R8 mfhi");
        check(rvalid_o, "R8 mfhi timing", rvalid_o, 1);
        drain();
        issue(6'h12, 32'd0, 32'd0, "R8 mflo");
        drain();
        // R9 start while busy ignored
        issue(6'h18, 32'd3, 32'd5, "R9 mult survives");
        start_i = 1'b1; func_i = 6'h11; opa_i = 32'hDEAD_DEAD;
        @(negedge clk);
        start_i = 1'b0;
        drain();
        check(hi_o == 32'd0 && lo_o == 32'd15, "R9 hi after ignored mthi", {hi_o, lo_o}, 64'd15);
        // R10 held read behind divide
        issue(6'h1B, 32'd1000, 32'd7, "R10 divu before read");
        issue(6'h12, 32'd0, 32'd0, "R10 held mflo");
        check(rvalid_o && rdata_o == 32'd142, "R10 held read", rdata_o, 32'd142);
        drain();
        // R11 illegal codes
        issue(6'h14, 32'h1, 32'h1, "R11 illegal 0x14");
        check(!busy_o, "R11 no busy", busy_o, 0);
        drain();
        issue(6'h00, 32'h5, 32'h5, "R11 illegal 0x00");
        drain();
        // R1 reset clears loaded registers
        issue(6'h11, 32'h1234_5678, 32'd0, "R7 mthi before reset");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(hi_o == 0 && lo_o == 0, "R1 reset clears", {hi_o, lo_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule